// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timer with Soft Ramp

This block times the two secondary-side synchronous rectifier gates of a half-bridge resonant converter. Each rectifier gate follows one primary gate: the high-side rectifier gate follows the high-side primary gate, and the low-side rectifier gate follows the low-side primary gate. Because the two primary gates alternate, the rectifier gates also alternate on successive half-cycles. All timing is counted in clock cycles of `clk`.

A rectifier gate turns on when its primary gate rises. In continuous-conduction operation the turn-on waits a programmable delay. The gate turns off at the earliest of three events:
- its own on-time expires;
- a point that lies a programmable advance before the expected primary falling edge is reached;
- the primary gate actually falls.

Each time the supervisor enables the block, the on-time starts at one tenth of nominal. It then climbs in eight levels, and each level lasts sixteen switching cycles. After 128 cycles the full width applies and a ramp-done flag is raised. Removing the enable forces both gates low in the same cycle and clears the ramp.

Top module: `srg_gate_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `sr_hi`, `sr_lo` and `ramp_done` are 0.
- R2: `sr_hi` is high only in cycles that follow a clock edge at which `pri_hi` was sampled high. `sr_lo` follows `pri_lo` in the same way. `sr_hi` and `sr_lo` are never high together.
- R3: Let e be the count of clock edges since the edge at which the matching primary input was first sampled high, so that e = 0 at that edge. The gate register loads 1 at that edge exactly when all of these hold: the block is enabled, the primary is high, e >= D, e < D + W, and e + `adv_cnt` < `pri_width`. The gate output shows the loaded value after the edge.
- R4: D equals `dly_cnt` when `ccm_mode` is 1, and D equals 0 when `ccm_mode` is 0.
- R5: Let c be the ramp count and t be `ton_nom`. W is chosen as follows:
  - if c >= 128, W = t;
  - if c < 16, W = floor(t/10);
  - otherwise W = max(floor(t*(floor(c/16)+1)/8), floor(t/10)).
  W is taken from the count held before the current edge.
- R6: The ramp count increases by 1 at each edge where `pri_hi` is sampled high after being sampled low, while `sr_en` is 1. The count saturates at 128. `ramp_done` is 1 exactly while the count is 128.
- R7: When `sr_en` is 0, `sr_hi` and `sr_lo` are 0 in that same cycle, without waiting for a clock edge.
- R8: An edge with `sr_en` low clears the ramp count to 0. After the block is enabled again, the pulses start from the first level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_en | input | 1 | Rectifier enable from the supervisor |
| ccm_mode | input | 1 | Continuous-conduction flag; selects the turn-on delay |
| pri_hi | input | 1 | High-side primary gate |
| pri_lo | input | 1 | Low-side primary gate |
| pri_width | input | CW | Primary gate width in clocks |
| ton_nom | input | CW | Nominal rectifier on-time in clocks |
| adv_cnt | input | CW | Turn-off advance before the primary falling edge, in clocks |
| dly_cnt | input | CW | Turn-on delay in continuous conduction, in clocks |
| sr_hi | output | 1 | High-side rectifier gate |
| sr_lo | output | 1 | Low-side rectifier gate |
| ramp_done | output | 1 | The soft ramp has reached full width |

## Verification
A wrong elapsed count shows up as a rectifier pulse that starts or ends at the wrong clock. The error is visible at the gate output one edge after the faulty sample. A wrong ramp count or a wrong width level changes the pulse length on the next primary half-cycle. A count that fails to clear or to saturate shows up on `ramp_done` one edge later. The bench compares both gates and the flag with a behavioural model on every clock. It also measures pulse lengths directly at the first ramp level, at full width, under the turn-on delay and under the advance limit.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // Width of one ramp level; all values are in clock cycles.
  function automatic int unsigned srg_step_width(input int unsigned ton,
                                                 input int unsigned cnt,
                                                 input int unsigned step_cyc,
                                                 input int unsigned steps);
    int unsigned tenth;
    int unsigned lvl;
    int unsigned v;
    tenth = ton / 10;
    if (cnt >= step_cyc * steps) return ton;
    lvl = cnt / step_cyc;
    if (lvl == 0) return tenth;
    v = (ton * (lvl + 1)) / steps;
    return (v < tenth) ? tenth : v;
  endfunction
endpackage

// File: rtl/srg_ramp.sv
module srg_ramp #(
  parameter int CW       = 12,
  parameter int STEP_CYC = 16,
  parameter int STEPS    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pri_hi,
  input  logic [CW-1:0] ton,
  output logic [CW-1:0] width_o,
  output logic          done_o
);
  import srg_pkg::*;
  localparam int TOTAL = STEP_CYC * STEPS;
  localparam int RW    = $clog2(TOTAL + 1);

  logic          hi_q;
  logic [RW-1:0] cnt_q;
  logic          hi_rise;

  assign hi_rise = pri_hi & ~hi_q;
  assign done_o  = (cnt_q == RW'(TOTAL));
  assign width_o = CW'(srg_step_width(32'(ton), 32'(cnt_q),
                                      STEP_CYC, STEPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hi_q <= pri_hi;
      if (!en)
        cnt_q <= '0;
      else if (hi_rise && (cnt_q < RW'(TOTAL)))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  ramp_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt_q >= $past(cnt_q)));
  // R6
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && en) |=> done_o);
  // R8
  ramp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done_o);
endmodule

// File: rtl/srg_chan.sv
module srg_chan #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pri,
  input  logic          ccm,
  input  logic [CW-1:0] p_width,
  input  logic [CW-1:0] adv,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] width,
  output logic          gate_o
);
  logic          pri_q;
  logic [CW-1:0] e_q;
  logic [CW-1:0] e_now;
  logic [CW-1:0] d_eff;
  logic          rise;
  logic          in_on;
  logic          before_adv;
  logic          gate_d;
  logic          gate_q;

  assign rise       = pri & ~pri_q;
  assign e_now      = rise ? '0 : ((&e_q) ? e_q : e_q + 1'b1);
  assign d_eff      = ccm ? dly : '0;
  assign in_on      = (e_now >= d_eff) &&
                      ({1'b0, e_now} < ({1'b0, d_eff} + {1'b0, width}));
  assign before_adv = ({1'b0, e_now} + {1'b0, adv}) < {1'b0, p_width};
  assign gate_d     = en & pri & in_on & before_adv;
  assign gate_o     = gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= 1'b0;
      e_q    <= '0;
      gate_q <= 1'b0;
    end else begin
      pri_q  <= pri;
      e_q    <= e_now;
      gate_q <= gate_d;
    end
  end

  // R2
  gate_in_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri |=> !gate_q);
  // R4
  ccm_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ccm && (dly != '0)) |=> !gate_q);
endmodule

// File: rtl/srg_gate_timer.sv
module srg_gate_timer #(
  parameter int CW       = 12,
  parameter int STEP_CYC = 16,
  parameter int STEPS    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_en,
  input  logic          ccm_mode,
  input  logic          pri_hi,
  input  logic          pri_lo,
  input  logic [CW-1:0] pri_width,
  input  logic [CW-1:0] ton_nom,
  input  logic [CW-1:0] adv_cnt,
  input  logic [CW-1:0] dly_cnt,
  output logic          sr_hi,
  output logic          sr_lo,
  output logic          ramp_done
);
  localparam int NCH = 2;

  logic [CW-1:0]  width_w;
  logic [NCH-1:0] pri_v;
  logic [NCH-1:0] gate_w;

  assign pri_v = {pri_lo, pri_hi};

  srg_ramp #(.CW(CW), .STEP_CYC(STEP_CYC), .STEPS(STEPS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(sr_en), .pri_hi(pri_hi),
    .ton(ton_nom), .width_o(width_w), .done_o(ramp_done));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    srg_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(sr_en), .pri(pri_v[g]),
      .ccm(ccm_mode), .p_width(pri_width), .adv(adv_cnt),
      .dly(dly_cnt), .width(width_w), .gate_o(gate_w[g]));
  end

  assign sr_hi = gate_w[0] & sr_en;
  assign sr_lo = gate_w[1] & sr_en;

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_hi && sr_lo));
endmodule

// File: tb/srg_gate_timer_tb.sv
module srg_gate_timer_tb;
  localparam int CW = 12;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_en = 1'b0, ccm_mode = 1'b0, pri_hi = 1'b0, pri_lo = 1'b0;
  logic [CW-1:0] pri_width = '0, ton_nom = '0, adv_cnt = '0, dly_cnt = '0;
  logic sr_hi, sr_lo, ramp_done;

  int errors = 0, checks = 0;
  int last_hi = 0, run_hi = 0;
  int both_seen = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cnt = 0, m_e_hi = 0, m_e_lo = 0;
  bit m_ph = 0, m_pl = 0, m_g_hi = 0, m_g_lo = 0;

  always #5 clk = ~clk;

  srg_gate_timer #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .ccm_mode(ccm_mode),
    .pri_hi(pri_hi), .pri_lo(pri_lo), .pri_width(pri_width),
    .ton_nom(ton_nom), .adv_cnt(adv_cnt), .dly_cnt(dly_cnt),
    .sr_hi(sr_hi), .sr_lo(sr_lo), .ramp_done(ramp_done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ramp_w(input int c, input int t);
    int lvl, v;
    if (c >= 128) return t;
    if (c < 16) return t / 10;
    lvl = c >> 4;
    v = (t * (lvl + 1)) >> 3;
    if (v < t / 10) v = t / 10;
    return v;
  endfunction

  function automatic bit win(input int e, input int w);
    int d;
    d = ccm_mode ? int'(dly_cnt) : 0;
    return (e >= d) && (e < d + w) && (e + int'(adv_cnt) < int'(pri_width));
  endfunction

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_pl = 0; m_g_hi = 0; m_g_lo = 0;
      m_e_hi = 0; m_e_lo = 0;
    end else begin
      w = ramp_w(m_cnt, int'(ton_nom));
      m_e_hi = (pri_hi && !m_ph) ? 0 : m_e_hi + 1;
      m_e_lo = (pri_lo && !m_pl) ? 0 : m_e_lo + 1;
      m_g_hi = sr_en && pri_hi && win(m_e_hi, w);
      m_g_lo = sr_en && pri_lo && win(m_e_lo, w);
      if (!sr_en) m_cnt = 0;
      else if (pri_hi && !m_ph && m_cnt < 128) m_cnt++;
      m_ph = pri_hi; m_pl = pri_lo;
    end
    #2;
    chk({cur_req, " sr_hi"}, int'(sr_hi), int'(m_g_hi && sr_en));
    chk({cur_req, " sr_lo"}, int'(sr_lo), int'(m_g_lo && sr_en));
    chk({cur_req, " ramp_done"}, int'(ramp_done), int'(m_cnt >= 128));
    if (sr_hi && sr_lo) both_seen++;
    if (sr_hi) run_hi++;
    else if (run_hi > 0) begin last_hi = run_hi; run_hi = 0; end
  end

  task automatic sw_cycle(input int half, input int dead);
    pri_hi = 1'b1; repeat (half) @(negedge clk);
    pri_hi = 1'b0; repeat (dead) @(negedge clk);
    pri_lo = 1'b1; repeat (half) @(negedge clk);
    pri_lo = 1'b0; repeat (dead) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sr_hi", int'(sr_hi), 0);
    chk("R1 reset ramp_done", int'(ramp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release sr_lo", int'(sr_lo), 0);
    // main ramp: ton 40, width 60, advance 5
    ton_nom = 40; pri_width = 60; adv_cnt = 5; dly_cnt = 25;
    cur_req = "R3/R5/R6"; sr_en = 1'b1;
    @(negedge clk);
    sw_cycle(60, 4);
    chk("R5 first level width", last_hi, 4);
    chk("R6 not done early", int'(ramp_done), 0);
    repeat (127) sw_cycle(60, 4);
    chk("R6 done after 128", int'(ramp_done), 1);
    sw_cycle(60, 4);
    chk("R5 full width", last_hi, 40);
    // turn-on delay in continuous conduction
    cur_req = "R4"; ccm_mode = 1'b1;
    sw_cycle(60, 4);
    chk("R4 delayed width", last_hi, 30);
    ccm_mode = 1'b0;
    // advance limit
    cur_req = "R3"; ton_nom = 80;
    sw_cycle(60, 4);
    chk("R3 advance limited width", last_hi, 55);
    // enable drop mid-pulse
    cur_req = "R7/R8"; ton_nom = 40;
    pri_hi = 1'b1; repeat (10) @(negedge clk);
    chk("R7 gate high before drop", int'(sr_hi), 1);
    sr_en = 1'b0; #1;
    chk("R7 immediate low", int'(sr_hi), 0);
    @(negedge clk); pri_hi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 ramp cleared", int'(ramp_done), 0);
    sr_en = 1'b1; @(negedge clk);
    sw_cycle(60, 4);
    chk("R8 restart first level", last_hi, 4);
    chk("R2 no overlap seen", both_seen, 0);
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule